// File: doc/BRIEF.md
# Activate and Column Command Spacing Gate

This block sits in front of a DRAM command bus and answers, within the same cycle, whether a proposed row-activate (ACT) or column (CAS) command may go out. The device behind the bus has 32 banks arranged as 8 bank groups of 4 banks. Four spacing rules apply. At most four ACTs may fall inside any rolling activate window, counted across all banks. ACT commands have one minimum gap when they target the same bank group and another when they target different groups. CAS commands follow the same pattern with their own pair of gaps.

The scheduler places a candidate on `cmd_i`, `bg_i` and `bank_i` and reads `allow_o` in that same cycle. When it sends the command, it raises `issue_i` for that cycle. Only an issue strobe updates the gate's history, and the new history takes effect from the next cycle on. The gate does not choose commands, and it does not enforce per-bank row timing.

All timestamps come from one free-running counter. Its width is derived from the longest rule, and its comparisons remain correct when it wraps. A history entry that is older than every rule it could affect is retired. A long idle period therefore never produces a false block.

Top module: `cmd_spacing_gate`

## Requirements
- R1: After reset, with no issue yet, `allow_o` is 1 for any ACT (`cmd_i`=2'b01) or CAS (`cmd_i`=2'b10) to any group and bank.
- R2: After an ACT issue to group g and bank b in cycle t, an ACT to group g with a bank other than b is refused in cycles t+1 to t+T_ACT_SAME-1 (default 8) and is allowed from cycle t+T_ACT_SAME on, provided no other rule blocks it.
- R3: After an ACT issue to group g in cycle t, an ACT to any other group is refused until cycle t+T_ACT_DIFF (default 12).
- R4: An ACT to the same bank as the most recent ACT of its group is exempt from the same-group ACT gap. The cross-group gap and the activate window still apply to it.
- R5: If four ACTs have issued and the oldest of the latest four issued in cycle t, a further ACT is refused before cycle t+T_FAW (default 40).
- R6: After a CAS issue to group g in cycle t, a CAS to group g is refused until cycle t+T_CAS_SAME (default 8).
- R7: After a CAS issue to group g in cycle t, a CAS to any other group is refused until cycle t+T_CAS_DIFF (default 16).
- R8: ACT history and CAS history are independent: a CAS issue never restricts an ACT, and an ACT issue never restricts a CAS.
- R9: `allow_o` is a combinational function of the current candidate and the history. A candidate presented without `issue_i` leaves the history unchanged.
- R10: For `cmd_i` of 2'b00 (idle) or 2'b11 (reserved), `allow_o` is 1 and an issue records nothing.
- R11: The rules stay correct after the internal timestamp counter wraps. An idle period of any length leaves every command allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; clears all history |
| cmd_i | input | 2 | Candidate command: 00 idle, 01 ACT, 10 CAS, 11 reserved |
| bg_i | input | 3 | Bank group of the candidate |
| bank_i | input | 2 | Bank within the group |
| issue_i | input | 1 | Candidate is sent this cycle; record it in the history |
| allow_o | output | 1 | Candidate satisfies every spacing rule this cycle |

## Verification
`allow_o` is due in the same cycle as the candidate, with no register in its path. An issue captured at a rising edge first affects `allow_o` in the cycle that follows. A gap of N cycles therefore means the blocked candidate is refused at elapsed counts 1 to N-1 and allowed at count N. The bench drives each candidate just after the falling edge and samples `allow_o` 1 ns later, well before the next rising edge. It stamps every issue in its reference model with the index of the cycle whose rising edge captures it, so expected and actual values line up to the exact threshold cycle of every rule.

// File: rtl/cmd_spacing_gate_pkg.sv
package cmd_spacing_gate_pkg;

  typedef enum logic [1:0] {
    CG_IDLE = 2'b00,
    CG_ACT  = 2'b01,
    CG_CAS  = 2'b10,
    CG_RSVD = 2'b11
  } cg_cmd_e;

  function automatic int cg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cg_tick_counter.sv
// Free-running timestamp source shared by all history stores.
module cg_tick_counter #(
  parameter int TS_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_i,
  output logic [TS_W-1:0] now_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) now_o <= '0;
    else       now_o <= now_o + 1'b1;
  end

endmodule

// File: rtl/cg_group_history.sv
// One timestamp per bank group for the most recent recorded command.
// An entry retires once its age reaches EXPIRE, which keeps the
// modular age comparison valid across counter wrap.
module cg_group_history #(
  parameter int NUM_BG = 8,
  parameter int BG_W   = 3,
  parameter int TS_W   = 7,
  parameter int EXPIRE = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [TS_W-1:0]            now_i,
  input  logic                       wr_i,
  input  logic [BG_W-1:0]            wr_bg_i,
  output logic [NUM_BG-1:0][TS_W-1:0] age_o,
  output logic [NUM_BG-1:0]          live_o
);

  localparam logic [TS_W-1:0] EXPIRE_T = TS_W'(EXPIRE);

  logic [NUM_BG-1:0][TS_W-1:0] stamp_q;

  for (genvar g = 0; g < NUM_BG; g++) begin : g_grp
    assign age_o[g] = now_i - stamp_q[g];

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        stamp_q[g] <= '0;
        live_o[g]  <= 1'b0;
      end else if (wr_i && (wr_bg_i == BG_W'(g))) begin
        stamp_q[g] <= now_i;
        live_o[g]  <= 1'b1;
      end else if (live_o[g] && (age_o[g] >= EXPIRE_T)) begin
        live_o[g]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cg_act_window.sv
// Shift register of the latest DEPTH activate timestamps. A new
// activate is blocked while the oldest live entry is younger than WINDOW.
module cg_act_window #(
  parameter int DEPTH  = 4,
  parameter int TS_W   = 7,
  parameter int WINDOW = 40
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [TS_W-1:0] now_i,
  input  logic            push_i,
  output logic            block_o
);

  localparam logic [TS_W-1:0] WINDOW_T = TS_W'(WINDOW);

  logic [DEPTH-1:0][TS_W-1:0] stamp_q;
  logic [DEPTH-1:0][TS_W-1:0] age;
  logic [DEPTH-1:0]           live_q;
  logic [DEPTH-1:0]           fresh;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign age[k]   = now_i - stamp_q[k];
    assign fresh[k] = live_q[k] && (age[k] < WINDOW_T);

    if (k == 0) begin : g_head
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          stamp_q[k] <= '0;
          live_q[k]  <= 1'b0;
        end else if (push_i) begin
          stamp_q[k] <= now_i;
          live_q[k]  <= 1'b1;
        end else if (!fresh[k]) begin
          live_q[k]  <= 1'b0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          stamp_q[k] <= '0;
          live_q[k]  <= 1'b0;
        end else if (push_i) begin
          stamp_q[k] <= stamp_q[k-1];
          live_q[k]  <= fresh[k-1];
        end else if (!fresh[k]) begin
          live_q[k]  <= 1'b0;
        end
      end
    end
  end

  assign block_o = fresh[DEPTH-1];

endmodule

// File: rtl/cmd_spacing_gate.sv
// Same-cycle permission gate for ACT and CAS commands on a grouped-bank
// DRAM command bus.
module cmd_spacing_gate
  import cmd_spacing_gate_pkg::*;
#(
  parameter int NUM_BG       = 8,
  parameter int BANKS_PER_BG = 4,
  parameter int ACT_WINDOW   = 4,
  parameter int T_FAW        = 40,
  parameter int T_ACT_SAME   = 8,
  parameter int T_ACT_DIFF   = 12,
  parameter int T_CAS_SAME   = 8,
  parameter int T_CAS_DIFF   = 16,
  localparam int BG_W        = $clog2(NUM_BG),
  localparam int BK_W        = $clog2(BANKS_PER_BG)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [1:0]      cmd_i,
  input  logic [BG_W-1:0] bg_i,
  input  logic [BK_W-1:0] bank_i,
  input  logic            issue_i,
  output logic            allow_o
);

  localparam int ACT_EXPIRE = cg_max(T_ACT_SAME, T_ACT_DIFF);
  localparam int CAS_EXPIRE = cg_max(T_CAS_SAME, T_CAS_DIFF);
  localparam int LIMIT_MAX  = cg_max(T_FAW, cg_max(ACT_EXPIRE, CAS_EXPIRE));
  localparam int TS_W       = $clog2(LIMIT_MAX + 1) + 1;

  localparam logic [TS_W-1:0] ACT_SAME_T = TS_W'(T_ACT_SAME);
  localparam logic [TS_W-1:0] ACT_DIFF_T = TS_W'(T_ACT_DIFF);
  localparam logic [TS_W-1:0] CAS_SAME_T = TS_W'(T_CAS_SAME);
  localparam logic [TS_W-1:0] CAS_DIFF_T = TS_W'(T_CAS_DIFF);

  cg_cmd_e cmd;
  assign cmd = cg_cmd_e'(cmd_i);

  logic is_act, is_cas;
  assign is_act = (cmd == CG_ACT);
  assign is_cas = (cmd == CG_CAS);

  logic [TS_W-1:0] now;

  cg_tick_counter #(.TS_W(TS_W)) u_tick (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .now_o (now)
  );

  logic [NUM_BG-1:0][TS_W-1:0] act_age, cas_age;
  logic [NUM_BG-1:0]           act_live, cas_live;

  cg_group_history #(
    .NUM_BG (NUM_BG), .BG_W (BG_W), .TS_W (TS_W), .EXPIRE (ACT_EXPIRE)
  ) u_act_hist (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .now_i   (now),
    .wr_i    (issue_i && is_act),
    .wr_bg_i (bg_i),
    .age_o   (act_age),
    .live_o  (act_live)
  );

  cg_group_history #(
    .NUM_BG (NUM_BG), .BG_W (BG_W), .TS_W (TS_W), .EXPIRE (CAS_EXPIRE)
  ) u_cas_hist (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .now_i   (now),
    .wr_i    (issue_i && is_cas),
    .wr_bg_i (bg_i),
    .age_o   (cas_age),
    .live_o  (cas_live)
  );

  logic faw_block;

  cg_act_window #(
    .DEPTH (ACT_WINDOW), .TS_W (TS_W), .WINDOW (T_FAW)
  ) u_window (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .now_i   (now),
    .push_i  (issue_i && is_act),
    .block_o (faw_block)
  );

  // Bank of the latest ACT per group, for the same-bank exemption.
  logic [NUM_BG-1:0][BK_W-1:0] last_bank_q;

  for (genvar g = 0; g < NUM_BG; g++) begin : g_bank
    always_ff @(posedge clk_i) begin
      if (rst_i)                                    last_bank_q[g] <= '0;
      else if (issue_i && is_act && bg_i == BG_W'(g)) last_bank_q[g] <= bank_i;
    end
  end

  logic [NUM_BG-1:0] act_hold, cas_hold;

  for (genvar g = 0; g < NUM_BG; g++) begin : g_rule
    logic            own_grp;
    logic [TS_W-1:0] act_need, cas_need;
    assign own_grp  = (bg_i == BG_W'(g));
    assign act_need = own_grp ? ((bank_i == last_bank_q[g]) ? '0 : ACT_SAME_T)
                              : ACT_DIFF_T;
    assign cas_need = own_grp ? CAS_SAME_T : CAS_DIFF_T;
    assign act_hold[g] = act_live[g] && (act_age[g] < act_need);
    assign cas_hold[g] = cas_live[g] && (cas_age[g] < cas_need);
  end

  always_comb begin
    unique case (cmd)
      CG_ACT:  allow_o = !faw_block && (act_hold == '0);
      CG_CAS:  allow_o = (cas_hold == '0);
      default: allow_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cmd_spacing_gate_chk.sv
// Port-level properties. The next-cycle checks rely on every gap being
// at least 2 cycles, which holds for all legal settings.
module cmd_spacing_gate_chk #(
  parameter int BG_W = 3,
  parameter int BK_W = 2
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic [1:0]      cmd_i,
  input logic [BG_W-1:0] bg_i,
  input logic [BK_W-1:0] bank_i,
  input logic            issue_i,
  input logic            allow_o
);

  // R1
  a_r1_fresh_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> allow_o);

  // R2
  a_r2_act_same_group: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && cmd_i == 2'b01) |=>
      (!(cmd_i == 2'b01 && bg_i == $past(bg_i) && bank_i != $past(bank_i)) || !allow_o));

  // R3
  a_r3_act_cross_group: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && cmd_i == 2'b01) |=>
      (!(cmd_i == 2'b01 && bg_i != $past(bg_i)) || !allow_o));

  // R6
  a_r6_cas_same_group: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && cmd_i == 2'b10) |=>
      (!(cmd_i == 2'b10 && bg_i == $past(bg_i)) || !allow_o));

  // R7
  a_r7_cas_cross_group: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && cmd_i == 2'b10) |=>
      (!(cmd_i == 2'b10 && bg_i != $past(bg_i)) || !allow_o));

  // R10
  a_r10_idle_allowed: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == 2'b00 || cmd_i == 2'b11) |-> allow_o);

endmodule

bind cmd_spacing_gate cmd_spacing_gate_chk #(.BG_W(BG_W), .BK_W(BK_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .cmd_i   (cmd_i),
  .bg_i    (bg_i),
  .bank_i  (bank_i),
  .issue_i (issue_i),
  .allow_o (allow_o)
);

// File: tb/cmd_spacing_gate_tb_top.sv
module cmd_spacing_gate_tb_top;

  localparam int NBG    = 8;
  localparam int NBK    = 4;
  localparam int FAW    = 40;
  localparam int A_SAME = 8;
  localparam int A_DIFF = 12;
  localparam int C_SAME = 8;
  localparam int C_DIFF = 16;
  localparam int NEVER  = -1000000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [2:0] bg = '0;
  logic [1:0] bank = '0;
  logic       issue = 1'b0;
  logic       allow;

  always #10 clk = ~clk;

  cmd_spacing_gate dut_i (
    .clk_i (clk), .rst_i (rst), .cmd_i (cmd), .bg_i (bg),
    .bank_i (bank), .issue_i (issue), .allow_o (allow)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int la [NBG];
  int lb [NBG];
  int lc [NBG];
  int fw [4];

  function automatic bit model_allow(input logic [1:0] c, input int g, input int b, input int now);
    if (c == 2'b01) begin
      if (now - fw[3] < FAW) return 1'b0;
      for (int h = 0; h < NBG; h++) begin
        int need;
        need = (h == g) ? ((b == lb[h]) ? 0 : A_SAME) : A_DIFF;
        if (now - la[h] < need) return 1'b0;
      end
    end else if (c == 2'b10) begin
      for (int h = 0; h < NBG; h++) begin
        if (now - lc[h] < ((h == g) ? C_SAME : C_DIFF)) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: allow=%0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  // One cycle: present a candidate, check allow, optionally issue it.
  task automatic step(input logic [1:0] c, input int g, input int b, input bit want, input string tag);
    bit e;
    @(negedge clk);
    cmd = c; bg = 3'(g); bank = 2'(b); issue = 1'b0;
    #1;
    e = model_allow(c, g, b, cyc);
    check(allow, e, tag);
    issue = want && allow;
    @(posedge clk);
    if (issue) begin
      if (c == 2'b01) begin
        la[g] = cyc; lb[g] = b;
        fw[3] = fw[2]; fw[2] = fw[1]; fw[1] = fw[0]; fw[0] = cyc;
      end else if (c == 2'b10) begin
        lc[g] = cyc;
      end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, 0, 0, 1'b0, "R10");
  endtask

  initial begin
    #3000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int h = 0; h < NBG; h++) begin la[h] = NEVER; lb[h] = 0; lc[h] = NEVER; end
    for (int k = 0; k < 4; k++) fw[k] = NEVER;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, nothing blocked
    step(2'b01, 0, 0, 1'b0, "R1");
    step(2'b10, 3, 1, 1'b0, "R1");
    // R10: idle and reserved codes, reserved issue records nothing
    step(2'b00, 2, 0, 1'b1, "R10");
    step(2'b11, 2, 0, 1'b1, "R10");
    step(2'b01, 2, 1, 1'b0, "R10");

    // R2: same group, other bank; probes without issue exercise R9
    step(2'b01, 0, 0, 1'b1, "R2");
    for (int i = 0; i < 10; i++) step(2'b01, 0, 1, 1'b0, "R2");
    step(2'b01, 0, 2, 1'b0, "R9");
    idle(45);

    // R4 then R3
    step(2'b01, 1, 0, 1'b1, "R3");
    step(2'b01, 1, 0, 1'b0, "R4");
    for (int i = 0; i < 14; i++) step(2'b01, 4, 3, 1'b0, "R3");
    idle(60);

    // R5: four activates 8 apart in one group, then a fifth elsewhere
    for (int k = 0; k < 4; k++) begin
      step(2'b01, 2, k, 1'b1, "R5");
      if (k < 3) idle(7);
    end
    for (int i = 0; i < 20; i++) step(2'b01, 6, 0, 1'b0, "R5");
    idle(60);

    // R6 and R7
    step(2'b10, 0, 0, 1'b1, "R6");
    for (int i = 0; i < 10; i++) step(2'b10, 0, 1, 1'b0, "R6");
    idle(30);
    step(2'b10, 0, 0, 1'b1, "R7");
    for (int i = 0; i < 18; i++) step(2'b10, 7, 0, 1'b0, "R7");
    idle(30);

    // R8: cross-type independence
    step(2'b01, 3, 0, 1'b1, "R8");
    step(2'b10, 3, 0, 1'b1, "R8");
    step(2'b01, 3, 0, 1'b0, "R8");
    step(2'b10, 3, 0, 1'b0, "R8");

    // R11: idle past counter wrap, then gaps still exact
    idle(300);
    step(2'b01, 5, 1, 1'b0, "R11");
    step(2'b10, 5, 1, 1'b0, "R11");
    step(2'b01, 0, 0, 1'b1, "R11");
    for (int i = 0; i < 10; i++) step(2'b01, 0, 2, 1'b0, "R11");
    idle(50);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r, g, b;
      logic [1:0] c;
      r = int'($urandom % 10);
      g = int'($urandom % NBG);
      b = int'($urandom % NBK);
      c = (r < 5) ? 2'b01 : (r < 9) ? 2'b10 : 2'(($urandom % 2) * 3);
      step(c, g, b, ($urandom % 4) != 0,
           (c == 2'b01) ? "R5" : (c == 2'b10) ? "R7" : "R10");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule